// File: doc/BRIEF.md
# Compare-pair PWM timer channel

This block is one channel of a timer. A 16-bit up-counter advances on a selectable count tick. The tick comes either from a prescaler that divides the system clock by 1, 2, 4 or 8, or from edges of an external clock input. That input is synchronised into the system clock domain first, and the active edge is selectable. Two compare registers sit beside the counter. In PWM mode a match on compare A drives output pin A high and a match on compare B drives it low. Either match can be chosen to clear the counter, and that choice sets the period of the waveform. By placing the two values inside or outside the period, software can produce any duty from 0% to 100%.

Software programs the channel through a small write-only register port. The control word holds:
- the count source and the external edge;
- the clear source;
- the PWM enable and the start bit;
- an output action for each pin.

Pin B always follows its own action on compare-B matches. Pin A follows its own action only when PWM mode is off.

Top module: `cmp_pwm_channel`

## Requirements
- R1: After synchronous reset, the count is 0, both pins are 0, every register is 0 and the counter is stopped.
- R2: A write with `wr_en` high stores `wr_data` at the rising edge: address 0 is the control word, address 1 is compare A and address 2 is compare B. A write to address 3 changes nothing. The control word layout is: bits [2:0] count source, [4:3] external edge, [6:5] clear source, [7] PWM enable, [8] start, [10:9] pin-A action, [12:11] pin-B action.
- R3: While the start bit is 0, the count holds its value and no compare match occurs.
- R4: Count source values 0 to 3 divide the system clock by 1, 2, 4 or 8. A prescaler counts clock cycles from reset, and a tick occurs in each cycle whose cycle number modulo the divisor equals divisor-1.
- R5: A count source with bit 2 set counts edges of `ext_clk`. Edge code 0 counts rising edges, 1 counts falling edges, and 2 or 3 count both. The input passes through two synchronising flops, so a change made before edge k moves the count at edge k+2.
- R6: A compare match is a count tick taken while the count equals the compare value. In PWM mode, pin A goes to 1 at the edge of a compare-A match and goes to 0 at the edge of a compare-B match.
- R7: The clear source selects what ends the period: 1 clears the count to 0 in place of the increment on a compare-A match, and 2 does the same on a compare-B match. Codes 0 and 3 let the counter run freely, wrapping from 65535 to 0.
- R8: In PWM mode, when both compare registers hold the same value, a match leaves pin A unchanged.
- R9: With PWM mode off, a compare-A match applies the pin-A action to pin A. The action codes are 0 hold, 1 drive 0, 2 drive 1 and 3 toggle.
- R10: In both modes, a compare-B match applies the pin-B action (same codes) to pin B.
- R11: In PWM mode, a compare value that the count never reaches gives a constant waveform: 0% duty when clearing on B with compare A beyond it, and 100% duty when clearing on A with compare B beyond it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| ext_clk | input | 1 | External count clock, asynchronous |
| count | output | 16 | Current counter value |
| pin_a | output | 1 | PWM / compare-A output |
| pin_b | output | 1 | Compare-B output |

## Verification
A write becomes visible at the rising edge that captures it. It governs the counter from the next edge on, so a start written at edge k first moves the count at edge k+1. Count, pin A and pin B all change together at the edge that ends a tick cycle. An `ext_clk` change reaches the count two edges after the first synchroniser captures it. The bench drives inputs and compares all three outputs against its behavioural model at the falling edge, half a period after the model and the design have both updated. The delta and edge-detection checks allow settle cycles that cover the synchroniser delay.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int CNT_W_DEF = 16;
    localparam int ADDR_W    = 2;
    localparam int PRE_W     = 3;  // supports division by 2**3

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMPA = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMPB = 2'd2;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        CLR_FREE = 2'd0,
        CLR_ON_A = 2'd1,
        CLR_ON_B = 2'd2,
        CLR_RSVD = 2'd3
    } clr_sel_e;

    typedef struct packed {
        pin_act_e   act_b;
        pin_act_e   act_a;
        logic       start;
        logic       pwm_en;
        clr_sel_e   clr;
        logic [1:0] edge_sel;
        logic [2:0] clk_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic step;
        logic hit_a;
        logic hit_b;
    } match_t;

    function automatic logic apply_act(pin_act_e act, logic cur);
        case (act)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

    function automatic logic edge_hit(logic [1:0] sel, logic cur, logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        if (sel[1]) return rise | fall;
        return sel[0] ? fall : rise;
    endfunction

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            cmp_a <= '0;
            cmp_b <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: ctrl  <= ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_CMPA: cmp_a <= wr_data;
                ADDR_CMPB: cmp_b <= wr_data;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/cpwm_tick.sv
module cpwm_tick
    import cpwm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] clk_sel,
    input  logic [1:0] edge_sel,
    input  logic       ext_in,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             int_tick;
    logic             ext_tick;
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        mask     = PRE_W'((32'd1 << clk_sel[1:0]) - 32'd1);
        int_tick = ((pre_q & mask) == mask);
    end

    // synchroniser stages plus one history flop for edge detection
    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)         sh_q[g] <= 1'b0;
                else if (g == 0) sh_q[g] <= ext_in;
                else             sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign ext_tick = edge_hit(edge_sel, sh_q[SYNC_STAGES-1], sh_q[SYNC_STAGES]);
    assign tick     = clk_sel[2] ? ext_tick : int_tick;

endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  clr_sel_e         clr,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic [CNT_W-1:0] count,
    output match_t           m
);

    logic do_clear;

    always_comb begin
        m.step   = run & tick;
        m.hit_a  = m.step & (count == cmp_a);
        m.hit_b  = m.step & (count == cmp_b);
        do_clear = ((clr == CLR_ON_A) & m.hit_a) | ((clr == CLR_ON_B) & m.hit_b);
    end

    always_ff @(posedge clk) begin
        if (rst)           count <= '0;
        else if (m.step)   count <= do_clear ? '0 : count + 1'b1;
    end

endmodule

// File: rtl/cpwm_pins.sv
module cpwm_pins
    import cpwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwm_en,
    input  pin_act_e act_a,
    input  pin_act_e act_b,
    input  match_t   m,
    output logic     pin_a,
    output logic     pin_b
);

    logic nxt_a;
    logic nxt_b;

    always_comb begin
        nxt_a = pin_a;
        if (pwm_en) begin
            if (m.hit_a && !m.hit_b)      nxt_a = 1'b1;
            else if (m.hit_b && !m.hit_a) nxt_a = 1'b0;
        end else if (m.hit_a) begin
            nxt_a = apply_act(act_a, pin_a);
        end
        nxt_b = m.hit_b ? apply_act(act_b, pin_b) : pin_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_a <= 1'b0;
            pin_b <= 1'b0;
        end else begin
            pin_a <= nxt_a;
            pin_b <= nxt_b;
        end
    end

endmodule

// File: rtl/cmp_pwm_channel.sv
module cmp_pwm_channel
    import cpwm_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ext_clk,
    output logic [CNT_W-1:0]  count,
    output logic              pin_a,
    output logic              pin_b
);

    ctrl_t            ctl;
    logic [CNT_W-1:0] cmp_a_q;
    logic [CNT_W-1:0] cmp_b_q;
    logic             tick;
    match_t           m;
    logic             run_w;
    logic             pwm_w;

    assign run_w = ctl.start;
    assign pwm_w = ctl.pwm_en;

    cpwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl(ctl), .cmp_a(cmp_a_q), .cmp_b(cmp_b_q)
    );

    cpwm_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst(rst), .clk_sel(ctl.clk_sel), .edge_sel(ctl.edge_sel),
        .ext_in(ext_clk), .tick(tick)
    );

    cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run_w), .tick(tick), .clr(ctl.clr),
        .cmp_a(cmp_a_q), .cmp_b(cmp_b_q), .count(count), .m(m)
    );

    cpwm_pins u_pins (
        .clk(clk), .rst(rst), .pwm_en(pwm_w), .act_a(ctl.act_a), .act_b(ctl.act_b),
        .m(m), .pin_a(pin_a), .pin_b(pin_b)
    );

endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic             pin_a,
    input logic             pin_b,
    input logic             run,
    input logic             pwm_en,
    input logic [CNT_W-1:0] cmp_a,
    input logic [CNT_W-1:0] cmp_b
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0 && !pin_a && !pin_b));

    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

    assert_step_or_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(count) |-> (count == CNT_W'($past(count) + 1'b1) || count == '0));

    assert_equal_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(pwm_en) && ($past(cmp_a) == $past(cmp_b))) |-> (pin_a == $past(pin_a)));

    assert_rise_on_a_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(pwm_en) && pin_a && !$past(pin_a)) |-> ($past(count) == $past(cmp_a)));

    assert_fall_on_b_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(pwm_en) && !pin_a && $past(pin_a)) |-> ($past(count) == $past(cmp_b)));

endmodule

bind cmp_pwm_channel cpwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .count(count), .pin_a(pin_a), .pin_b(pin_b),
    .run(run_w), .pwm_en(pwm_w), .cmp_a(cmp_a_q), .cmp_b(cmp_b_q)
);

// File: tb/cmp_pwm_channel_test.sv
module cmp_pwm_channel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ext_clk = 1'b0;
    logic [15:0] count;
    logic        pin_a;
    logic        pin_b;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;  // 125 MHz

    cmp_pwm_channel uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_clk(ext_clk), .count(count), .pin_a(pin_a), .pin_b(pin_b)
    );

    // ---------------- behavioural reference model ----------------
    int m_pre, m_ctrl, m_ca, m_cb, m_cnt, m_pa, m_pb, m_s1, m_s2, m_s3;

    function automatic int act_of(int code, int cur);
        if (code == 1) return 0;
        if (code == 2) return 1;
        if (code == 3) return 1 - cur;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_ctrl = 0; m_ca = 0; m_cb = 0; m_cnt = 0;
            m_pa = 0; m_pb = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            int sel, edg, clr, pwm, st, aa, ab, div;
            bit tk, ha, hb;
            sel = m_ctrl & 7; edg = (m_ctrl >> 3) & 3; clr = (m_ctrl >> 5) & 3;
            pwm = (m_ctrl >> 7) & 1; st = (m_ctrl >> 8) & 1;
            aa = (m_ctrl >> 9) & 3; ab = (m_ctrl >> 11) & 3;
            if (sel >= 4) begin
                if (edg >= 2)      tk = (m_s2 != m_s3);
                else if (edg == 0) tk = (m_s2 == 1 && m_s3 == 0);
                else               tk = (m_s2 == 0 && m_s3 == 1);
            end else begin
                div = 1 << sel;
                tk = ((m_pre % div) == div - 1);
            end
            ha = (st == 1) && tk && (m_cnt == m_ca);
            hb = (st == 1) && tk && (m_cnt == m_cb);
            if (pwm == 1) begin
                if (ha && !hb)      m_pa = 1;
                else if (hb && !ha) m_pa = 0;
            end else if (ha) m_pa = act_of(aa, m_pa);
            if (hb) m_pb = act_of(ab, m_pb);
            if (st == 1 && tk) begin
                if ((clr == 1 && ha) || (clr == 2 && hb)) m_cnt = 0;
                else m_cnt = (m_cnt + 1) % 65536;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
            m_pre = (m_pre + 1) % 8;
            if (wr_en) begin
                if (wr_addr == 0)      m_ctrl = wr_data & 'h1FFF;
                else if (wr_addr == 1) m_ca = wr_data;
                else if (wr_addr == 2) m_cb = wr_data;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk({cur_req, " count"}, count, m_cnt);
            chk({cur_req, " pin_a"}, pin_a, m_pa);
            chk({cur_req, " pin_b"}, pin_b, m_pb);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic int mkctl(int cs, int edg, int clr, int pwm, int st, int aa, int ab);
        return cs | (edg << 3) | (clr << 5) | (pwm << 7) | (st << 8) | (aa << 9) | (ab << 11);
    endfunction

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
            summary();
        end
    end

    initial begin
        int c0, c1, mx, prev, toggles, seen;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", count, 0); chk("R1 pin_a", pin_a, 0); chk("R1 pin_b", pin_b, 0);
        cur_req = "R3"; idle(5);
        chk("R3 stopped after reset", count, 0);

        // R6 PWM set on A, reset on B, clear on B
        cur_req = "R6";
        wr(1, 3); wr(2, 9);
        wr(0, mkctl(0, 0, 2, 1, 1, 0, 0));
        prev = pin_a; seen = 0;
        for (int i = 0; i < 40 && seen == 0; i++) begin
            @(negedge clk);
            if (pin_a && prev == 0) begin chk("R6 rise count", count, 4); seen = 1; end
            prev = pin_a;
        end
        chk("R6 rise seen", seen, 1);
        seen = 0;
        for (int i = 0; i < 40 && seen == 0; i++) begin
            @(negedge clk);
            if (!pin_a && prev == 1) begin chk("R6 fall count", count, 0); seen = 1; end
            prev = pin_a;
        end
        chk("R6 fall seen", seen, 1);

        // R3 stop holds count
        cur_req = "R3";
        wr(0, mkctl(0, 0, 2, 1, 0, 0, 0));
        c0 = count; idle(10);
        chk("R3 hold", count, c0);

        // R4 prescaler divisors
        for (int s = 0; s < 4; s++) begin
            cur_req = "R4";
            do_reset();
            wr(0, mkctl(s, 0, 0, 0, 1, 0, 0));
            idle(3);
            c0 = count; idle(64); c1 = count;
            chk("R4 ticks per 64 cycles", (c1 - c0) & 'hFFFF, 64 >> s);
        end

        // R7 clear on A
        cur_req = "R7";
        do_reset();
        wr(1, 4); wr(2, 2);
        wr(0, mkctl(0, 0, 1, 1, 1, 0, 0));
        mx = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (count > mx) mx = count; end
        chk("R7 clear on A max", mx, 4);

        // R7 reserved clear code runs freely and wraps
        do_reset();
        wr(1, 7); wr(2, 100);
        wr(0, mkctl(0, 0, 3, 1, 1, 0, 0));
        seen = 0;
        for (int i = 0; i < 70000 && seen == 0; i++) begin
            @(negedge clk);
            if (count == 65535) seen = 1;
        end
        chk("R7 reached 65535", seen, 1);
        @(negedge clk);
        chk("R7 wrap to zero", count, 0);

        // R8 equal compare values, with pin B toggling in PWM mode (R10)
        cur_req = "R8";
        do_reset();
        wr(1, 5); wr(2, 5);
        wr(0, mkctl(0, 0, 2, 1, 1, 0, 3));
        toggles = 0; prev = pin_a;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); if (pin_a != prev) toggles++; prev = pin_a;
        end
        chk("R8 pin_a unchanged", toggles, 0);
        chk("R10 pin_b toggled in PWM mode", pin_b, m_pb);

        // R9 compare mode, pin A toggles on A; R10 pin B driven high then low
        cur_req = "R9";
        do_reset();
        wr(1, 1); wr(2, 6);
        wr(0, mkctl(0, 0, 2, 0, 1, 3, 2));
        idle(10);
        toggles = 0; prev = pin_a;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk); if (pin_a != prev) toggles++; prev = pin_a;
        end
        chk("R9 toggles per two periods", toggles, 2);
        chk("R10 pin_b driven high", pin_b, 1);
        cur_req = "R10";
        wr(0, mkctl(0, 0, 2, 0, 1, 3, 1));
        idle(10);
        chk("R10 pin_b driven low", pin_b, 0);

        // R5 external clock, each edge mode
        for (int e = 0; e < 3; e++) begin
            cur_req = "R5";
            do_reset();
            wr(0, mkctl(4, e, 0, 0, 1, 0, 0));
            idle(4);
            c0 = count;
            for (int p = 0; p < 10; p++) begin
                ext_clk = 1'b1; idle(4);
                ext_clk = 1'b0; idle(4);
            end
            idle(4);
            c1 = count;
            chk("R5 external edges counted", (c1 - c0) & 'hFFFF, (e == 2) ? 20 : 10);
        end

        // R11 duty extremes
        cur_req = "R11";
        do_reset();
        wr(1, 20); wr(2, 5);
        wr(0, mkctl(0, 0, 2, 1, 1, 0, 0));
        idle(12);
        seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (pin_a) seen = 1; end
        chk("R11 zero duty", seen, 0);
        do_reset();
        wr(1, 5); wr(2, 20);
        wr(0, mkctl(0, 0, 1, 1, 1, 0, 0));
        idle(12);
        seen = 1;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (!pin_a) seen = 0; end
        chk("R11 full duty", seen, 1);

        // R2 address 3 write is ignored
        cur_req = "R2";
        do_reset();
        wr(1, 1000); wr(2, 2000);
        wr(0, mkctl(0, 0, 0, 1, 1, 0, 0));
        c0 = count;
        wr(3, 'hFFFF);
        c1 = count;
        chk("R2 addr 3 no effect on counting", (c1 - c0) & 'hFFFF, 2);
        idle(5);
        chk("R2 pin_a unaffected", pin_a, 0);

        summary();
    end

endmodule